// File: doc/BRIEF.md
# Line REI Receive Error Counter

This block keeps a running performance count of the far-end line block errors reported by the remote end. Once per received frame, the framing logic presents the received line remote-error-indication byte together with a one-cycle frame strobe and a valid flag. The block compares the byte with a maximum that depends on the configured line rate. A byte above that maximum contributes nothing. An accepted byte is added to a 16-bit accumulator that saturates at its top value.

A control processor reads the count by issuing a one-cycle latch request. On that request the accumulator is copied into a holding register and the accumulator restarts at zero in the same cycle. The output always shows the holding register, so the value read stays fixed until the next latch. A byte that arrives in the same cycle as a latch request is counted in the new period. Counting takes place only while the count-enable bit is set.

Top module: `rei_err_counter`

## Requirements
- R1: After reset, `count_out` is 0x0000 and the accumulator is empty, so a latch with no accepted frames since reset returns 0x0000.
- R2: While `count_en` is 0, sampled REI bytes leave the accumulator unchanged. A latch taken afterwards returns only what was counted while `count_en` was 1.
- R3: With `rate_mode` = 2'b00 (four independent STM-1 streams), a byte of 0x18 or less adds its value and a byte above 0x18 adds zero.
- R4: With `rate_mode` = 2'b01 (STM-4/STS-12), a byte of 0x60 or less adds its value and a byte above 0x60 adds zero.
- R5: With `rate_mode` = 2'b10 (STM-16), every byte value 0x00 to 0xFF adds its value. Code 2'b11 behaves the same as 2'b10.
- R6: A byte is sampled only in a cycle where both `frame_strobe` and `rei_valid` are 1. A strobe without valid, or valid without a strobe, adds nothing.
- R7: The accumulator saturates at 0xFFFF and never wraps.
- R8: A `latch_req` pulse copies the accumulator into the holding register and clears the accumulator in the same cycle. A byte sampled in that same cycle is counted in the new period.
- R9: `count_out` changes only on the clock edge that takes a latch request, and shows the new value from that edge onward. Between latches it holds, whatever frames arrive.
- R10: A change of `rate_mode` takes effect at the next frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_strobe | input | 1 | One-cycle pulse, once per received frame |
| rei_valid | input | 1 | The REI byte is valid |
| rei_byte | input | 8 | Received line REI byte |
| rate_mode | input | 2 | 00 quad STM-1, 01 STM-4/STS-12, 10 or 11 STM-16 |
| count_en | input | 1 | Enables accumulation |
| latch_req | input | 1 | One-cycle request to snapshot and clear the accumulator |
| count_out | output | 16 | Count held at the last snapshot |

## Verification
The accumulator takes in a sampled byte on the clock edge where strobe and valid are both high. Because the accumulator is not visible at the ports, every count is observed through a latch. The latch is taken up on one edge, and `count_out` carries the result from that edge onward. The bench therefore drives inputs on falling edges and reads `count_out` on the falling edge that follows the rising edge which took the latch. For the hold checks, the bench sends further frames and reads `count_out` again without issuing a latch.

// File: rtl/rei_pkg.sv
package rei_pkg;
  typedef enum logic [1:0] {
    RATE_QUAD_STM1 = 2'b00,
    RATE_STM4      = 2'b01,
    RATE_STM16     = 2'b10,
    RATE_STM16_ALT = 2'b11
  } rate_t;
endpackage

// File: rtl/rei_rst_sync.sv
module rei_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rei_range_filter.sv
module rei_range_filter
  import rei_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] LIM_STM1 = 8'h18,
  parameter logic [BYTE_W-1:0] LIM_STM4 = 8'h60
) (
  input  rate_t             rate,
  input  logic [BYTE_W-1:0] rei_in,
  output logic [BYTE_W-1:0] accepted
);
  logic over_limit;

  always_comb begin
    unique case (rate)
      RATE_QUAD_STM1: over_limit = (rei_in > LIM_STM1);
      RATE_STM4:      over_limit = (rei_in > LIM_STM4);
      default:        over_limit = 1'b0;
    endcase
    accepted = over_limit ? '0 : rei_in;
  end

  // R3 R4: an accepted value never exceeds the limit of its rate
  always_comb begin
    if (rate == RATE_QUAD_STM1) a_r3_stm1_limit: assert (accepted <= LIM_STM1);
    if (rate == RATE_STM4)      a_r4_stm4_limit: assert (accepted <= LIM_STM4);
  end
endmodule

// File: rtl/rei_accum.sv
module rei_accum #(
  parameter int ACC_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              count_en,
  input  logic              latch,
  input  logic [BYTE_W-1:0] add_val,
  output logic [ACC_W-1:0]  acc
);
  localparam int SUM_W = ACC_W + 1;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] sum;
  logic             take, acc_ce;

  always_comb begin
    take   = sample && count_en;
    acc_ce = take || latch;
    sum    = SUM_W'(acc_q) + SUM_W'(add_val);
    acc_d  = acc_q;
    if (latch)             acc_d = take ? ACC_W'(add_val) : '0;
    else if (take) begin
      if (sum[ACC_W])      acc_d = ACC_MAX;
      else                 acc_d = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R7: without a latch the accumulator never decreases
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> acc_q >= $past(acc_q));
  // R2: disabled and not latched means the count holds
  a_r2_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !latch) |=> $stable(acc_q));
  // R8: a latch with no sample leaves the accumulator empty
  a_r8_clear_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && !sample) |=> acc_q == '0);
endmodule

// File: rtl/rei_snapshot.sv
module rei_snapshot #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch,
  input  logic [ACC_W-1:0] acc_in,
  output logic [ACC_W-1:0] hold
);
  logic [ACC_W-1:0] hold_q, hold_d;

  always_comb hold_d = latch ? acc_in : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (latch) hold_q <= hold_d;
  end

  assign hold = hold_q;

  // R8: the holding register captures the pre-latch accumulator
  a_r8_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> hold_q == $past(acc_in));
  // R9: no latch, no change of the output
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(hold_q));
endmodule

// File: rtl/rei_err_counter.sv
module rei_err_counter
  import rei_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] LIM_STM1 = 8'h18,
  parameter logic [BYTE_W-1:0] LIM_STM4 = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_strobe,
  input  logic              rei_valid,
  input  logic [BYTE_W-1:0] rei_byte,
  input  logic [1:0]        rate_mode,
  input  logic              count_en,
  input  logic              latch_req,
  output logic [ACC_W-1:0]  count_out
);
  logic              rst_sync_n;
  logic              sample;
  logic [BYTE_W-1:0] accepted;
  logic [ACC_W-1:0]  acc;
  rate_t             rate;

  assign sample = frame_strobe && rei_valid;
  assign rate   = rate_t'(rate_mode);

  rei_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rei_range_filter #(.BYTE_W(BYTE_W), .LIM_STM1(LIM_STM1), .LIM_STM4(LIM_STM4)) u_filt (
    .rate(rate), .rei_in(rei_byte), .accepted(accepted)
  );

  rei_accum #(.ACC_W(ACC_W), .BYTE_W(BYTE_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .sample(sample), .count_en(count_en),
    .latch(latch_req), .add_val(accepted), .acc(acc)
  );

  rei_snapshot #(.ACC_W(ACC_W)) u_snap (
    .clk(clk), .rst_n(rst_sync_n), .latch(latch_req), .acc_in(acc), .hold(count_out)
  );
endmodule

// File: tb/rei_err_counter_test.sv
module rei_err_counter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_strobe, rei_valid, count_en, latch_req;
  logic [7:0]  rei_byte;
  logic [1:0]  rate_mode;
  logic [15:0] count_out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rei_err_counter uut (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .rei_valid(rei_valid),
    .rei_byte(rei_byte), .rate_mode(rate_mode), .count_en(count_en),
    .latch_req(latch_req), .count_out(count_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] b, input logic v = 1'b1, input logic s = 1'b1);
    @(negedge clk);
    frame_strobe = s; rei_valid = v; rei_byte = b;
    @(negedge clk);
    frame_strobe = 1'b0; rei_valid = 1'b0;
  endtask

  task automatic latch_check(input string req, input logic [15:0] exp);
    @(negedge clk); latch_req = 1'b1;
    @(negedge clk); latch_req = 1'b0;
    check(req, count_out, exp);
  endtask

  task automatic t_reset;
    check("R1 reset out", count_out, 16'h0000);
    latch_check("R1 empty after reset", 16'h0000);
  endtask

  task automatic t_stm1;
    rate_mode = 2'b00;
    frame(8'h18); frame(8'h19); frame(8'h05); frame(8'hFF);
    latch_check("R3 stm1 limit", 16'h001D);
  endtask

  task automatic t_stm4;
    rate_mode = 2'b01;
    frame(8'h60); frame(8'h61); frame(8'h18); frame(8'h80);
    latch_check("R4 stm4 limit", 16'h0078);
  endtask

  task automatic t_stm16;
    rate_mode = 2'b10;
    frame(8'hFF); frame(8'h61); frame(8'h00);
    latch_check("R5 stm16 accept", 16'h0160);
    rate_mode = 2'b11;
    frame(8'hFE); frame(8'h19);
    latch_check("R5 code 11", 16'h0117);
  endtask

  task automatic t_enable;
    rate_mode = 2'b10;
    count_en = 1'b0;
    frame(8'h40); frame(8'h22);
    count_en = 1'b1;
    frame(8'h03);
    latch_check("R2 disabled ignored", 16'h0003);
  endtask

  task automatic t_qualify;
    rate_mode = 2'b10;
    frame(8'h50, 1'b0, 1'b1);
    frame(8'h50, 1'b1, 1'b0);
    frame(8'h07);
    latch_check("R6 strobe and valid", 16'h0007);
  endtask

  task automatic t_saturate;
    rate_mode = 2'b10;
    for (int i = 0; i < 258; i++) frame(8'hFF);
    latch_check("R7 saturate", 16'hFFFF);
    latch_check("R7 cleared after", 16'h0000);
  endtask

  task automatic t_same_cycle;
    rate_mode = 2'b10;
    frame(8'h10);
    @(negedge clk);
    latch_req = 1'b1; frame_strobe = 1'b1; rei_valid = 1'b1; rei_byte = 8'h07;
    @(negedge clk);
    latch_req = 1'b0; frame_strobe = 1'b0; rei_valid = 1'b0;
    check("R8 old period", count_out, 16'h0010);
    latch_check("R8 new period", 16'h0007);
  endtask

  task automatic t_hold;
    rate_mode = 2'b10;
    frame(8'h21);
    latch_check("R9 latched", 16'h0021);
    frame(8'h33); frame(8'h44);
    check("R9 holds between latches", count_out, 16'h0021);
    latch_check("R9 next latch", 16'h0077);
  endtask

  task automatic t_mode_change;
    rate_mode = 2'b10;
    frame(8'h30);
    rate_mode = 2'b00;
    frame(8'h30);
    frame(8'h02);
    rate_mode = 2'b01;
    frame(8'h30);
    latch_check("R10 mode at next strobe", 16'h0062);
  endtask

  initial begin
    rst_n = 1'b0; frame_strobe = 1'b0; rei_valid = 1'b0; rei_byte = '0;
    rate_mode = 2'b00; count_en = 1'b1; latch_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_stm1();
    t_stm4();
    t_stm16();
    t_enable();
    t_qualify();
    t_saturate();
    t_same_cycle();
    t_hold();
    t_mode_change();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule